// File: doc/BRIEF.md
# Serial Frequency-Command Decoder

This block takes 32-bit command words from a three-wire serial port (active-low select, data, clock) and turns each one into a register write. A word names one of five targets: channel number, lowest band frequency, highest band frequency, channel spacing, or reference frequency. It carries a 24-bit mantissa and a decimal exponent. The mantissa is scaled by ten to that exponent over several cycles and the result is stored in the named register. Reserved target codes, malformed frames and results that do not fit are dropped.

After any write to the band start, the channel spacing or the channel number, the block works out the operating frequency as band start plus channel times spacing, using a sequential multiplier. It pulses a done strobe when the new value is in place. All results are held registers that stay valid until the next update, so a consumer samples them when it chooses and there is no back-pressure path. `busy` marks the window in which a command is being processed.

The serial pins are synchronised into `clk`, so the serial clock has to run several times slower than the system clock. The command fields are decoded by position, and the field positions are fixed.

Top module: `synth_cmd_decoder`

## Requirements
- R1: A data bit is shifted in, most significant bit first, on each rising edge of `ser_sck` while `ser_csn` is low. Clock edges while `ser_csn` is high shift nothing.
- R2: A frame is acted on only when `ser_csn` rises after exactly 32 clocked bits. A frame of any other length changes no output and does not raise `busy`.
- R3: Bits 31:28 select the target: 0 is channel, 1 is band start, 2 is band stop, 3 is spacing, 4 is reference. Codes 5 to 15 change no register and do not raise `busy`.
- R4: Bits 23:0 hold a mantissa and bits 27:24 an exponent n. The stored value is the mantissa times 10^n, computed one multiply by ten per cycle.
- R5: After a write to channel, band start or spacing, `freq_q` becomes (start + channel × spacing) modulo 2^32. `freq_done` pulses for exactly one cycle in the same cycle that `busy` falls, and `freq_q` changes at no other time.
- R6: A write to band stop or reference does not pulse `freq_done` and leaves `freq_q` unchanged.
- R7: Reset loads channel 0, start 1 900 000 000, stop 2 000 000 000, spacing 1 000 000, reference 20 000 000, `freq_q` equal to the start value, with `busy`, `cmd_err` and `freq_done` low.
- R8: If any step of the scaling exceeds 2^32−1, the target register keeps its value and `cmd_err` goes high. `cmd_err` stays high until the next command with a non-reserved target is accepted.
- R9: `busy` rises the cycle after an accepted frame and stays high until the write and any recompute finish. No register output changes except at an edge where `busy` was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_csn | input | 1 | Serial select, active low |
| ser_sck | input | 1 | Serial bit clock |
| ser_din | input | 1 | Serial data, MSB first |
| chan_q | output | 32 | Channel number register |
| start_q | output | 32 | Band start frequency (Hz) |
| stop_q | output | 32 | Band stop frequency (Hz) |
| step_q | output | 32 | Channel spacing (Hz) |
| ref_q | output | 32 | Reference frequency (Hz) |
| freq_q | output | 32 | Computed operating frequency (Hz) |
| freq_done | output | 1 | One-cycle strobe when `freq_q` is updated |
| busy | output | 1 | Command in progress |
| cmd_err | output | 1 | Last accepted command overflowed |

## Verification
The bench targets five failure modes.
- Frames of 31 and 33 bits: a counter that does not check the exact length would store a shifted word.
- Clock pulses sent while the select is high: a shifter that ignores the select would misalign the next frame.
- Exponents at the edge of 32 bits, namely 4×10^9 (which fits), 5×10^9 and 5×10^10 (which do not), and a zero mantissa with exponent 15: a checker that tests overflow only at the end, or tests it too early, would corrupt a register or flag an error falsely.
- A reserved target code: an incomplete decode would write a register.
- A channel number large enough to make the product wrap, and writes to stop and reference: arithmetic or recompute triggers that are wrong would show up as a bad `freq_q` or a spurious or missing strobe.

// File: rtl/synth_cmd_pkg.sv
package synth_cmd_pkg;
  localparam int TGT_W  = 4;
  localparam int EXP_W  = 4;
  localparam int MANT_W = 24;
  localparam int NUM_TGT = 5;

  typedef enum logic [TGT_W-1:0] {
    TGT_CHAN  = 4'd0,
    TGT_START = 4'd1,
    TGT_STOP  = 4'd2,
    TGT_STEP  = 4'd3,
    TGT_REF   = 4'd4
  } tgt_e;

  typedef struct packed {
    logic [TGT_W-1:0]  tgt;
    logic [EXP_W-1:0]  expo;
    logic [MANT_W-1:0] mant;
  } cmd_t;

  localparam int CMD_W = $bits(cmd_t);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCALE,
    ST_LOAD,
    ST_MUL
  } ctl_e;
endpackage

// File: rtl/synth_cmd_serial_rx.sv
module synth_cmd_serial_rx #(
  parameter int FRAME_W     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_csn,
  input  logic               ser_sck,
  input  logic               ser_din,
  output logic               frame_vld,
  output logic [FRAME_W-1:0] frame_word
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic [SYNC_STAGES-1:0] sck_sh, csn_sh, din_sh;
  logic sck_s, csn_s, din_s, sck_d, csn_d;
  logic sck_rise, csn_rise;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sh <= '0;
      csn_sh <= '1;
      din_sh <= '0;
      sck_d  <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sck_sh <= {sck_sh[SYNC_STAGES-2:0], ser_sck};
      csn_sh <= {csn_sh[SYNC_STAGES-2:0], ser_csn};
      din_sh <= {din_sh[SYNC_STAGES-2:0], ser_din};
      sck_d  <= sck_s;
      csn_d  <= csn_s;
    end
  end

  assign sck_s    = sck_sh[SYNC_STAGES-1];
  assign csn_s    = csn_sh[SYNC_STAGES-1];
  assign din_s    = din_sh[SYNC_STAGES-1];
  assign sck_rise = sck_s & ~sck_d;
  assign csn_rise = csn_s & ~csn_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      cnt        <= '0;
      frame_vld  <= 1'b0;
      frame_word <= '0;
    end else begin
      frame_vld <= 1'b0;
      if (csn_rise && (cnt == CNT_FULL)) begin
        frame_vld  <= 1'b1;
        frame_word <= shreg;
      end
      if (csn_s) begin
        cnt <= '0;
      end else if (sck_rise) begin
        shreg <= {shreg[FRAME_W-2:0], din_s};
        if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/synth_cmd_scaler.sv
module synth_cmd_scaler #(
  parameter int MANT_W = 24,
  parameter int EXP_W  = 4,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MANT_W-1:0] mant,
  input  logic [EXP_W-1:0]  expo,
  output logic              done,
  output logic              ovf,
  output logic [ACC_W-1:0]  result
);
  localparam int PROD_W = ACC_W + 4;

  logic [EXP_W-1:0]  cnt;
  logic              run;
  logic [PROD_W-1:0] prod;

  assign prod = ({4'b0, result} << 3) + ({4'b0, result} << 1);
  assign done = run && ((cnt == '0) || ovf);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      cnt    <= '0;
      ovf    <= 1'b0;
      run    <= 1'b0;
    end else if (start) begin
      result <= ACC_W'(mant);
      cnt    <= expo;
      ovf    <= 1'b0;
      run    <= 1'b1;
    end else if (run) begin
      if (done) begin
        run <= 1'b0;
      end else begin
        if (|prod[PROD_W-1:ACC_W]) ovf <= 1'b1;
        result <= prod[ACC_W-1:0];
        cnt    <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/synth_cmd_seq_mul.sv
module synth_cmd_seq_mul #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] mcand_in,
  input  logic [W-1:0] mplier_in,
  input  logic [W-1:0] addend,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     mcand, mplier;
  logic [CNT_W-1:0] cnt;
  logic             run;

  assign done = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand  <= '0;
      mplier <= '0;
      result <= '0;
      cnt    <= '0;
      run    <= 1'b0;
    end else if (start) begin
      mcand  <= mcand_in;
      mplier <= mplier_in;
      result <= addend;
      cnt    <= CNT_W'(W);
      run    <= 1'b1;
    end else if (run) begin
      if (done) begin
        run <= 1'b0;
      end else begin
        if (mplier[0]) result <= result + mcand;
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
        cnt    <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/synth_cmd_decoder.sv
module synth_cmd_decoder
  import synth_cmd_pkg::*;
#(
  parameter int          REG_W       = 32,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned CHAN_DEF    = 32'd0,
  parameter int unsigned START_DEF   = 32'd1900000000,
  parameter int unsigned STOP_DEF    = 32'd2000000000,
  parameter int unsigned STEP_DEF    = 32'd1000000,
  parameter int unsigned REF_DEF     = 32'd20000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_csn,
  input  logic             ser_sck,
  input  logic             ser_din,
  output logic [REG_W-1:0] chan_q,
  output logic [REG_W-1:0] start_q,
  output logic [REG_W-1:0] stop_q,
  output logic [REG_W-1:0] step_q,
  output logic [REG_W-1:0] ref_q,
  output logic [REG_W-1:0] freq_q,
  output logic             freq_done,
  output logic             busy,
  output logic             cmd_err
);
  localparam logic [REG_W-1:0] FREQ_RST = REG_W'(START_DEF + CHAN_DEF * STEP_DEF);
  localparam int SEL_W = $clog2(NUM_TGT);

  function automatic logic [REG_W-1:0] reg_default(input int idx);
    case (idx)
      0:       return REG_W'(CHAN_DEF);
      1:       return REG_W'(START_DEF);
      2:       return REG_W'(STOP_DEF);
      3:       return REG_W'(STEP_DEF);
      default: return REG_W'(REF_DEF);
    endcase
  endfunction

  logic             frame_vld;
  logic [CMD_W-1:0] frame_word;
  cmd_t             rx_cmd;
  logic             code_ok, accept;
  ctl_e             state;
  logic [SEL_W-1:0] tgt_q;
  logic             recalc_tgt;
  logic             scale_done, scale_ovf;
  logic [REG_W-1:0] scaled;
  logic             wr_en;
  logic             mul_start, mul_done;
  logic [REG_W-1:0] mul_res;
  logic [NUM_TGT-1:0][REG_W-1:0] regs;

  synth_cmd_serial_rx #(
    .FRAME_W    (CMD_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_csn   (ser_csn),
    .ser_sck   (ser_sck),
    .ser_din   (ser_din),
    .frame_vld (frame_vld),
    .frame_word(frame_word)
  );

  assign rx_cmd  = cmd_t'(frame_word);
  assign code_ok = (rx_cmd.tgt < TGT_W'(NUM_TGT));
  assign accept  = (state == ST_IDLE) && frame_vld && code_ok;

  synth_cmd_scaler #(
    .MANT_W(MANT_W),
    .EXP_W (EXP_W),
    .ACC_W (REG_W)
  ) u_scale (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .mant  (rx_cmd.mant),
    .expo  (rx_cmd.expo),
    .done  (scale_done),
    .ovf   (scale_ovf),
    .result(scaled)
  );

  assign wr_en      = (state == ST_SCALE) && scale_done && !scale_ovf;
  assign recalc_tgt = (tgt_q == SEL_W'(TGT_CHAN)) || (tgt_q == SEL_W'(TGT_START)) ||
                      (tgt_q == SEL_W'(TGT_STEP));
  assign mul_start  = (state == ST_LOAD);

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_reg
    logic [REG_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= reg_default(g);
      else if (wr_en && (tgt_q == SEL_W'(g))) q <= scaled;
    end
    assign regs[g] = q;
  end

  assign chan_q  = regs[TGT_CHAN];
  assign start_q = regs[TGT_START];
  assign stop_q  = regs[TGT_STOP];
  assign step_q  = regs[TGT_STEP];
  assign ref_q   = regs[TGT_REF];

  synth_cmd_seq_mul #(
    .W(REG_W)
  ) u_mul (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (mul_start),
    .mcand_in (chan_q),
    .mplier_in(step_q),
    .addend   (start_q),
    .done     (mul_done),
    .result   (mul_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      tgt_q     <= '0;
      cmd_err   <= 1'b0;
      freq_q    <= FREQ_RST;
      freq_done <= 1'b0;
    end else begin
      freq_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            tgt_q   <= rx_cmd.tgt[SEL_W-1:0];
            cmd_err <= 1'b0;
            state   <= ST_SCALE;
          end
        end
        ST_SCALE: begin
          if (scale_done) begin
            if (scale_ovf) begin
              cmd_err <= 1'b1;
              state   <= ST_IDLE;
            end else if (recalc_tgt) begin
              state <= ST_LOAD;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_LOAD: state <= ST_MUL;
        ST_MUL: begin
          if (mul_done) begin
            freq_q    <= mul_res;
            freq_done <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/synth_cmd_checker.sv
module synth_cmd_checker #(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] chan_q,
  input logic [REG_W-1:0] start_q,
  input logic [REG_W-1:0] stop_q,
  input logic [REG_W-1:0] step_q,
  input logic [REG_W-1:0] ref_q,
  input logic [REG_W-1:0] freq_q,
  input logic             freq_done,
  input logic             busy,
  input logic             cmd_err
);
  p_reg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> ($stable(chan_q) && $stable(start_q) && $stable(stop_q) &&
                      $stable(step_q) && $stable(ref_q)));

  p_done_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    freq_done |-> ($past(busy) && !busy));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    freq_done |=> !freq_done);

  p_done_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    freq_done |-> (freq_q == REG_W'(start_q + chan_q * step_q)));

  p_freq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !freq_done |-> $stable(freq_q));

  p_err_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_err) |-> ($past(busy) && !busy));
endmodule

bind synth_cmd_decoder synth_cmd_checker #(.REG_W(REG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .chan_q   (chan_q),
  .start_q  (start_q),
  .stop_q   (stop_q),
  .step_q   (step_q),
  .ref_q    (ref_q),
  .freq_q   (freq_q),
  .freq_done(freq_done),
  .busy     (busy),
  .cmd_err  (cmd_err)
);

// File: tb/synth_cmd_decoder_bench.sv
module synth_cmd_decoder_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_csn = 1'b1, ser_sck = 1'b0, ser_din = 1'b0;
  logic [31:0] chan_q, start_q, stop_q, step_q, ref_q, freq_q;
  logic freq_done, busy, cmd_err;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [31:0] m_reg [5];
  logic [31:0] m_freq;
  logic        m_err;
  bit          p_ok, p_ovf, p_recalc;
  int          p_sel;
  logic [31:0] p_val;
  bit          prev_busy = 0;

  always #10 clk = ~clk;

  synth_cmd_decoder u_synth_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .ser_csn(ser_csn), .ser_sck(ser_sck), .ser_din(ser_din),
    .chan_q(chan_q), .start_q(start_q), .stop_q(stop_q), .step_q(step_q), .ref_q(ref_q),
    .freq_q(freq_q), .freq_done(freq_done), .busy(busy), .cmd_err(cmd_err)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void scale_model(input logic [23:0] mant, input logic [3:0] e,
                                      output logic [31:0] v, output bit ovf);
    longint acc;
    acc = longint'(mant);
    ovf = 0;
    for (int i = 0; i < int'(e); i++) begin
      acc = acc * 10;
      if (acc > 64'hFFFF_FFFF) begin
        ovf = 1;
        break;
      end
    end
    v = acc[31:0];
  endfunction

  // Reference model: updated when a command completes, compared every idle cycle.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (prev_busy && !busy) begin
        if (p_ok) begin
          if (p_ovf) m_err = 1;
          else begin
            m_reg[p_sel] = p_val;
            m_err = 0;
            if (p_recalc) m_freq = m_reg[1] + m_reg[0] * m_reg[3];
          end
          p_ok = 0;
        end
        if (p_recalc) check(freq_done == 1'b1, "R5 done strobe missing", freq_done, 1);
        else          check(freq_done == 1'b0, "R6 unexpected done strobe", freq_done, 0);
      end else if (!busy) begin
        check(freq_done == 1'b0, "R5 stray done strobe", freq_done, 0);
      end
      if (!busy) begin
        check(chan_q  == m_reg[0], "R3 chan_q",  chan_q,  m_reg[0]);
        check(start_q == m_reg[1], "R3 start_q", start_q, m_reg[1]);
        check(stop_q  == m_reg[2], "R3 stop_q",  stop_q,  m_reg[2]);
        check(step_q  == m_reg[3], "R4 step_q",  step_q,  m_reg[3]);
        check(ref_q   == m_reg[4], "R4 ref_q",   ref_q,   m_reg[4]);
        check(freq_q  == m_freq,   "R5 freq_q",  freq_q,  m_freq);
        check(cmd_err == m_err,    "R8 cmd_err", cmd_err, m_err);
      end
      prev_busy = busy;
    end
  end

  task automatic send_bits(input logic [63:0] w, input int n);
    @(negedge clk) ser_csn = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      ser_din = w[i];
      repeat (3) @(negedge clk);
      ser_sck = 1'b1;
      repeat (3) @(negedge clk);
      ser_sck = 1'b0;
    end
    repeat (3) @(negedge clk);
    ser_csn = 1'b1;
  endtask

  task automatic expect_quiet(input string tag);
    bit saw = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (busy) saw = 1;
    end
    check(!saw, tag, saw, 0);
  endtask

  task automatic wait_done(input string tag);
    int t = 0;
    while (!busy && t < 40) begin @(negedge clk); t++; end
    check(busy == 1'b1, {tag, " R9 busy never rose"}, busy, 1);
    while (busy && t < 400) begin @(negedge clk); t++; end
    check(busy == 1'b0, {tag, " R9 busy stuck"}, busy, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [3:0] tgt, input logic [3:0] e, input logic [23:0] mant,
                          input string tag);
    logic [31:0] v;
    bit ovf;
    if (tgt < 5) begin
      scale_model(mant, e, v, ovf);
      p_sel    = int'(tgt);
      p_val    = v;
      p_ovf    = ovf;
      p_recalc = !ovf && (tgt == 0 || tgt == 1 || tgt == 3);
      p_ok     = 1;
    end
    send_bits({32'd0, tgt, e, mant}, 32);
    if (tgt < 5) wait_done(tag);
    else expect_quiet({tag, " R3 reserved code raised busy"});
  endtask

  initial begin
    m_reg[0] = 32'd0;          m_reg[1] = 32'd1900000000; m_reg[2] = 32'd2000000000;
    m_reg[3] = 32'd1000000;    m_reg[4] = 32'd20000000;
    m_freq   = 32'd1900000000; m_err = 0; p_ok = 0; p_recalc = 0;
    repeat (4) @(negedge clk);
    check(start_q == 32'd1900000000, "R7 reset start", start_q, 32'd1900000000);
    check(stop_q == 32'd2000000000 && ref_q == 32'd20000000, "R7 reset stop/ref", stop_q, 32'd2000000000);
    check(step_q == 32'd1000000 && chan_q == 0, "R7 reset step/chan", step_q, 32'd1000000);
    check(freq_q == 32'd1900000000, "R7 reset freq", freq_q, 32'd1900000000);
    check(!busy && !cmd_err && !freq_done, "R7 reset flags", {busy, cmd_err, freq_done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    send_cmd(4'd0, 4'd0, 24'd5, "R3 chan write");
    check(freq_q == 32'd1905000000, "R5 freq after chan", freq_q, 32'd1905000000);
    send_cmd(4'd3, 4'd4, 24'd25, "R4 step 25e4");
    check(step_q == 32'd250000, "R4 step scaled", step_q, 32'd250000);
    send_cmd(4'd1, 4'd6, 24'd1950, "R4 start 1950e6");
    send_cmd(4'd2, 4'd6, 24'd1999, "R6 stop write");
    send_cmd(4'd4, 4'd6, 24'd10, "R6 ref write");
    send_cmd(4'd7, 4'd0, 24'd99, "R3 reserved 7");
    send_cmd(4'd15, 4'd1, 24'd1, "R3 reserved 15");
    send_cmd(4'd3, 4'd10, 24'd5, "R8 overflow 5e10");
    check(cmd_err == 1'b1, "R8 err set", cmd_err, 1);
    send_cmd(4'd9, 4'd0, 24'd1, "R8 reserved keeps err");
    check(cmd_err == 1'b1, "R8 err held over reserved", cmd_err, 1);
    send_cmd(4'd1, 4'd9, 24'd4, "R8 boundary 4e9 fits");
    check(start_q == 32'd4000000000 && !cmd_err, "R8 4e9 stored", start_q, 32'd4000000000);
    send_cmd(4'd1, 4'd9, 24'd5, "R8 overflow 5e9");
    check(start_q == 32'd4000000000, "R8 start kept", start_q, 32'd4000000000);
    send_cmd(4'd3, 4'd15, 24'd0, "R4 zero mantissa exp15");
    send_cmd(4'd3, 4'd3, 24'd125, "R4 step 125e3");
    send_cmd(4'd0, 4'd0, 24'hFFFFFF, "R5 wrapping product");

    send_bits({32'd0, 4'd0, 4'd0, 24'd77}, 31);
    expect_quiet("R2 31-bit frame raised busy");
    send_bits({31'd0, 1'b1, 4'd0, 4'd0, 24'd77}, 33);
    expect_quiet("R2 33-bit frame raised busy");

    ser_din = 1'b1;
    for (int k = 0; k < 10; k++) begin
      repeat (3) @(negedge clk); ser_sck = 1'b1;
      repeat (3) @(negedge clk); ser_sck = 1'b0;
    end
    ser_din = 1'b0;
    expect_quiet("R1 clock with select high raised busy");
    send_cmd(4'd0, 4'd1, 24'd42, "R1 frame after idle clocks");
    check(chan_q == 32'd420, "R1 chan after idle clocks", chan_q, 32'd420);

    repeat (5) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R9: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule